// File: doc/BRIEF.md
# SDRAM Page-Mode Command Sequencer

This block sits between a single host port and one SDRAM device and turns each host request into the right command sequence for the memory. A request is a doubleword address plus a read/write flag, and a write carries one data word. The address splits into a row, an internal bank and a column. For every internal bank the sequencer remembers which row is open, if any. A request to the open row is a page hit and goes straight to the column command. A request to a closed bank first activates the row. A request to a different row in an open bank first precharges the bank and then activates the new row.

Reads always fetch a four-doubleword burst. The burst starts at the requested doubleword and wraps inside its aligned four-word group. Writes are single beats. The sequencer enforces the row-to-column delay, which is selectable as 2 or 3 clocks. It enforces a CAS latency of 2. It also enforces the minimum row-open time, which is derived from the row-to-column delay: that delay plus two clocks, and never less than five clocks. Only one request is in flight at a time. `req_ready` shows when the next one can be taken.

Top module: `sdram_page_seq`

## Requirements
- R1: Reset closes every bank record, raises `req_ready`, holds `mem_cmd` at NOP and keeps `host_rdy` and `mem_wr_en` low. The first access to any bank after reset is an ACT with no PRE before it, even if that row was open before the reset.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the request completes. `req_valid` and the request fields are ignored while `req_ready` is low.
- R3: On a page hit the column command appears in the second cycle after the accept cycle. It carries `mem_bank` equal to the bank field and `mem_addr` equal to the column, zero-extended.
- R4: On a page miss the sequencer issues PRE to the bank, then ACT to the same bank in the very next cycle with `mem_addr` equal to the new row, then the column command. A closed bank gets ACT directly. No command appears earlier than two cycles after the accept cycle.
- R5: The column command follows the ACT of its bank by exactly RCD clocks. RCD is 2 when `cfg_rcd_long` is 0 and 3 when it is 1.
- R6: PRE to a bank comes no earlier than tRAS clocks after the last ACT to that bank. tRAS is RCD+2, with a floor of 5 when RCD is 2. PRE is issued in the first cycle the rule allows.
- R7: A read issues one RD. `mem_rdata` is sampled at the ends of the cycles 2 to 5 after the RD cycle. `host_rdy` is high for four consecutive cycles starting three cycles after the RD cycle, and `host_rdata` carries the words in order.
- R8: During read beat i (i = 0..3), `host_beat` equals (column bits [1:0] + i) mod 4. The memory returns the word at column {col[7:2], (col[1:0]+i) mod 4}.
- R9: A write issues WR with `mem_wdata` equal to the request data. `mem_wr_en` and a single-cycle `host_rdy` pulse are high in that same cycle.
- R10: The `mem_cmd` encoding is NOP=0, ACT=1, RD=2, WR=3, PRE=4. The host address layout is `req_addr` = {row[22:10], bank[9:8], column[7:0]}.
- R11: `req_ready` is high again in the WR cycle of a write. For a read it is high again in the cycle of the fourth `host_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rcd_long | input | 1 | Row-to-column delay select: 0 gives 2 clocks, 1 gives 3 clocks |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 23 | Doubleword address {row, bank, column} |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Sequencer idle, so a request can be taken |
| host_rdy | output | 1 | One pulse per returned read word, or once per write |
| host_rdata | output | 32 | Returned read word |
| host_beat | output | 2 | Doubleword offset of the returned word within its group |
| mem_cmd | output | 3 | SDRAM command code |
| mem_bank | output | 2 | Internal bank select |
| mem_addr | output | 13 | Multiplexed row/column address |
| mem_wdata | output | 32 | Write data to the memory |
| mem_wr_en | output | 1 | Write data valid on `mem_wdata` |
| mem_rdata | input | 32 | Read data from the memory |

## Verification
The bench builds the block with its default parameters: 13-bit rows, four banks, 8-bit columns, CAS latency 2 and a four-beat burst. It runs two phases separated by a reset, the first with RCD of 2 and the second with RCD of 3. The RCD-2 phase reaches the five-clock floor on the row-open time. A write to a closed bank followed at once by a miss in the same bank makes that floor delay the precharge. Columns ending in 1, 2 and 3 reach every wrap point of the burst. Drawing rows from a set of three gives frequent hits, misses and re-opens across all four banks.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sdram_cmd_e;

  // Row-to-column delay in clocks from the configuration select.
  function automatic logic [3:0] rcd_clocks(input logic long_sel);
    return long_sel ? 4'd3 : 4'd2;
  endfunction

  // Minimum row-open time derived from the row-to-column delay.
  function automatic logic [3:0] ras_clocks(input logic [3:0] rcd);
    logic [3:0] t;
    t = rcd + 4'd2;
    if (rcd == 4'd2) t = 4'd5;
    return t;
  endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int AGE_W  = 3,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             act_fire,
  input  logic                             pre_fire,
  input  logic [BANK_W-1:0]                fire_bank,
  input  logic [ROW_W-1:0]                 fire_row,
  output logic [NBANK-1:0]                 open_o,
  output logic [NBANK-1:0][ROW_W-1:0]      row_o,
  output logic [NBANK-1:0][AGE_W-1:0]      age_o
);

  localparam logic [AGE_W-1:0] AGE_SAT = '1;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             is_open;
    logic [ROW_W-1:0] open_row;
    logic [AGE_W-1:0] age;
    logic             hit_sel;

    assign hit_sel = (fire_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        is_open  <= 1'b0;
        open_row <= '0;
        age      <= AGE_SAT;
      end else if (act_fire && hit_sel) begin
        is_open  <= 1'b1;
        open_row <= fire_row;
        age      <= '0;
      end else begin
        if (pre_fire && hit_sel) is_open <= 1'b0;
        if (age != AGE_SAT) age <= age + 1'b1;
      end
    end

    assign open_o[b] = is_open;
    assign row_o[b]  = open_row;
    assign age_o[b]  = age;
  end

endmodule

// File: rtl/sdram_burst_capture.sv
module sdram_burst_capture #(
  parameter int DATA_W    = 32,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W   = $clog2(BURST_LEN),
  localparam int CNT_W    = $clog2(CAS_LAT + BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] start_ofs,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              beat_rdy,
  output logic [DATA_W-1:0] beat_data,
  output logic [BEAT_W-1:0] beat_ofs,
  output logic              last_beat
);

  localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(CAS_LAT);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(CAS_LAT + BURST_LEN - 1);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [BEAT_W-1:0] start_q;
  logic              in_window;
  logic [CNT_W-1:0]  idx_full;

  assign in_window = active && (cnt >= FIRST_C) && (cnt <= LAST_C);
  assign last_beat = active && (cnt == LAST_C);
  assign idx_full  = cnt - FIRST_C;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      start_q   <= '0;
      beat_rdy  <= 1'b0;
      beat_data <= '0;
      beat_ofs  <= '0;
    end else begin
      if (start) begin
        active  <= 1'b1;
        cnt     <= '0;
        start_q <= start_ofs;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (last_beat) active <= 1'b0;
      end
      beat_rdy <= in_window;
      if (in_window) begin
        beat_data <= mem_rdata;
        beat_ofs  <= start_q + idx_full[BEAT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq #(
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 32,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  localparam int HADDR_W  = ROW_W + BANK_W + COL_W,
  localparam int BEAT_W   = $clog2(BURST_LEN),
  localparam int NBANK    = 1 << BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_rcd_long,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               host_rdy,
  output logic [DATA_W-1:0]  host_rdata,
  output logic [BEAT_W-1:0]  host_beat,
  output logic [2:0]         mem_cmd,
  output logic [BANK_W-1:0]  mem_bank,
  output logic [ROW_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_wr_en,
  input  logic [DATA_W-1:0]  mem_rdata
);
  import sdram_seq_pkg::*;

  localparam int AGE_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_BURST} seq_state_e;

  seq_state_e        state;
  logic              q_write;
  logic [BANK_W-1:0] q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;
  logic [DATA_W-1:0] q_wdata;
  logic              wr_rdy_q;

  logic [NBANK-1:0]            bank_open;
  logic [NBANK-1:0][ROW_W-1:0] bank_row;
  logic [NBANK-1:0][AGE_W-1:0] bank_age;

  logic             sel_open;
  logic             sel_row_hit;
  logic [AGE_W:0]   age_next;
  logic [3:0]       rcd_clk;
  logic [3:0]       ras_clk;
  logic             rcd_ok;
  logic             ras_ok;
  sdram_cmd_e       nxt_cmd;

  // Named internal events, also observed by the checker.
  logic ev_act, ev_pre, ev_col, ev_rd_start, ev_rbeat, ev_burst_last;
  logic [DATA_W-1:0] cap_data;
  logic [BEAT_W-1:0] cap_ofs;

  assign sel_open    = bank_open[q_bank];
  assign sel_row_hit = (bank_row[q_bank] == q_row);
  assign age_next    = {1'b0, bank_age[q_bank]} + 1'b1;
  assign rcd_clk     = rcd_clocks(cfg_rcd_long);
  assign ras_clk     = ras_clocks(rcd_clk);
  assign rcd_ok      = (4'(age_next) >= rcd_clk);
  assign ras_ok      = (4'(age_next) >= ras_clk);

  always_comb begin
    nxt_cmd = CMD_NOP;
    if (state == ST_BUSY) begin
      if (!sel_open)          nxt_cmd = CMD_ACT;
      else if (!sel_row_hit) begin
        if (ras_ok)           nxt_cmd = CMD_PRE;
      end else if (rcd_ok)    nxt_cmd = q_write ? CMD_WR : CMD_RD;
    end
  end

  assign ev_act      = (nxt_cmd == CMD_ACT);
  assign ev_pre      = (nxt_cmd == CMD_PRE);
  assign ev_col      = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);
  assign ev_rd_start = (nxt_cmd == CMD_RD);

  sdram_bank_track #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .AGE_W  (AGE_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_fire  (ev_act),
    .pre_fire  (ev_pre),
    .fire_bank (q_bank),
    .fire_row  (q_row),
    .open_o    (bank_open),
    .row_o     (bank_row),
    .age_o     (bank_age)
  );

  sdram_burst_capture #(
    .DATA_W    (DATA_W),
    .CAS_LAT   (CAS_LAT),
    .BURST_LEN (BURST_LEN)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ev_rd_start),
    .start_ofs (q_col[BEAT_W-1:0]),
    .mem_rdata (mem_rdata),
    .beat_rdy  (ev_rbeat),
    .beat_data (cap_data),
    .beat_ofs  (cap_ofs),
    .last_beat (ev_burst_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      q_write   <= 1'b0;
      q_bank    <= '0;
      q_row     <= '0;
      q_col     <= '0;
      q_wdata   <= '0;
      mem_cmd   <= CMD_NOP;
      mem_bank  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wr_en <= 1'b0;
      wr_rdy_q  <= 1'b0;
    end else begin
      mem_cmd   <= nxt_cmd;
      mem_wr_en <= ev_col && q_write;
      wr_rdy_q  <= ev_col && q_write;
      if (nxt_cmd != CMD_NOP) mem_bank <= q_bank;
      if (ev_act)      mem_addr <= q_row;
      else if (ev_col) mem_addr <= {{(ROW_W-COL_W){1'b0}}, q_col};
      else             mem_addr <= '0;
      if (ev_col && q_write) mem_wdata <= q_wdata;

      unique case (state)
        ST_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_col   <= req_addr[COL_W-1:0];
          q_bank  <= req_addr[COL_W +: BANK_W];
          q_row   <= req_addr[COL_W+BANK_W +: ROW_W];
          q_wdata <= req_wdata;
          state   <= ST_BUSY;
        end
        ST_BUSY: if (ev_col) state <= q_write ? ST_IDLE : ST_BURST;
        ST_BURST: if (ev_burst_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign host_rdy   = wr_rdy_q | ev_rbeat;
  assign host_rdata = cap_data;
  assign host_beat  = cap_ofs;

endmodule

// File: rtl/sdram_page_seq_chk.sv
module sdram_page_seq_chk #(
  parameter int BANK_W = 2,
  parameter int BEAT_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rcd_long,
  input logic              req_ready,
  input logic              host_rdy,
  input logic [BEAT_W-1:0] host_beat,
  input logic [2:0]        mem_cmd,
  input logic [BANK_W-1:0] mem_bank,
  input logic              mem_wr_en,
  input logic              ev_rbeat
);
  import sdram_seq_pkg::*;

  // Independent per-bank count of clocks since the last observed ACT.
  logic [3:0] ck_age [NBANK];
  logic [3:0] rcd_c, tras_c, ras_raw;

  assign rcd_c   = cfg_rcd_long ? 4'd3 : 4'd2;
  assign ras_raw = rcd_c + 4'd2;
  assign tras_c  = (ras_raw < 4'd5) ? 4'd5 : ras_raw;

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBANK; b++) begin
      if (!rst_n)
        ck_age[b] <= 4'hF;
      else if (mem_cmd == CMD_ACT && mem_bank == BANK_W'(b))
        ck_age[b] <= 4'd1;
      else if (ck_age[b] != 4'hF)
        ck_age[b] <= ck_age[b] + 4'd1;
    end
  end

  a_r5_rcd_met: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_RD || mem_cmd == CMD_WR) |-> ck_age[mem_bank] >= rcd_c);

  a_r6_ras_met: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_PRE) |-> ck_age[mem_bank] >= tras_c);

  a_r4_pre_then_act: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_PRE) |=> (mem_cmd == CMD_ACT && mem_bank == $past(mem_bank)));

  a_r2_busy_on_act: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_ACT) |-> !req_ready);

  a_r9_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_WR) |-> (host_rdy && mem_wr_en));

  a_r8_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rbeat && $past(ev_rbeat)) |-> host_beat == $past(host_beat) + 1'b1);

endmodule

bind sdram_page_seq sdram_page_seq_chk #(
  .BANK_W (BANK_W),
  .BEAT_W (BEAT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rcd_long (cfg_rcd_long),
  .req_ready    (req_ready),
  .host_rdy     (host_rdy),
  .host_beat    (host_beat),
  .mem_cmd      (mem_cmd),
  .mem_bank     (mem_bank),
  .mem_wr_en    (mem_wr_en),
  .ev_rbeat     (ev_rbeat)
);

// File: tb/sdram_page_seq_test.sv
module sdram_page_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rcd_long = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic        host_rdy;
  logic [31:0] host_rdata;
  logic [1:0]  host_beat;
  logic [2:0]  mem_cmd;
  logic [1:0]  mem_bank;
  logic [12:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_wr_en;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int tnow = 0;

  // Bench view of the bank state
  bit          m_open [4];
  logic [12:0] m_row  [4];
  int          m_act  [4];

  // Memory model state
  logic [12:0] mm_row [4];
  logic [31:0] sch_d  [8];

  always #5 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 1;

  sdram_page_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_rcd_long(cfg_rcd_long),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .host_rdy(host_rdy),
    .host_rdata(host_rdata), .host_beat(host_beat), .mem_cmd(mem_cmd),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr_en(mem_wr_en), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic [1:0] b, input logic [12:0] r,
                                      input logic [7:0] c);
    return {9'h1A5, r, b, c};
  endfunction

  function automatic int rcd_of(input logic lng);
    return lng ? 3 : 2;
  endfunction

  function automatic int ras_of(input int rcd);
    if (rcd == 2) return 5;
    return rcd + 2;
  endfunction

  // SDRAM data model: CAS latency 2, wrapping four-word burst
  always @(negedge clk) begin
    mem_rdata = sch_d[tnow % 8];
    if (rst_n && mem_cmd == 3'd1) mm_row[mem_bank] = mem_addr;
    if (rst_n && mem_cmd == 3'd2) begin
      for (int i = 0; i < 4; i++) begin
        logic [1:0] lo;
        lo = mem_addr[1:0] + 2'(i);
        sch_d[(tnow + 2 + i) % 8] = pat(mem_bank, mm_row[mem_bank], {mem_addr[7:2], lo});
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic lng);
    rst_n = 1'b0;
    req_valid = 1'b0;
    cfg_rcd_long = lng;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 1'b0;
      m_row[b] = '0;
      m_act[b] = -100;
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 1);
    check(mem_cmd == 3'd0, "R1 reset mem_cmd NOP", 32'(mem_cmd), 0);
    check(host_rdy == 1'b0 && mem_wr_en == 1'b0, "R1 reset strobes low",
          {30'd0, host_rdy, mem_wr_en}, 0);
  endtask

  task automatic run_req(input logic wr, input logic [1:0] b, input logic [12:0] r,
                         input logic [7:0] c, input logic [31:0] d, input bit junk);
    int a, t_pre, t_act, t_col, rcd;
    bit seq_bad;
    logic [2:0] col_cmd;
    while (!req_ready) @(negedge clk);
    a = tnow;
    rcd = rcd_of(cfg_rcd_long);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {r, b, c};
    req_wdata = d;
    t_pre = -1;
    t_act = -1;
    if (m_open[b] && m_row[b] == r) begin
      t_col = a + 2;
    end else if (!m_open[b]) begin
      t_act = a + 2;
      t_col = t_act + rcd;
    end else begin
      t_pre = a + 2;
      if (m_act[b] + ras_of(rcd) > t_pre) t_pre = m_act[b] + ras_of(rcd);
      t_act = t_pre + 1;
      t_col = t_act + rcd;
    end
    col_cmd = wr ? 3'd3 : 3'd2;

    @(negedge clk);
    check(req_ready == 1'b0, "R2 busy after accept", 32'(req_ready), 0);
    check(host_rdy == 1'b0, "R9 R7 no stray ready pulse", 32'(host_rdy), 0);
    seq_bad = 1'b0;
    while (tnow < t_col) begin
      if (junk) begin
        req_valid = 1'b1;
        req_write = ~wr;
        req_addr  = 23'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      if (tnow == t_pre) begin
        check(mem_cmd == 3'd4 && mem_bank == b, "R6 R4 precharge timing/bank",
              {27'd0, mem_bank, mem_cmd}, {27'd0, b, 3'd4});
      end else if (tnow == t_act) begin
        check(mem_cmd == 3'd1 && mem_bank == b && mem_addr == r,
              "R4 R1 activate row", {14'd0, mem_bank, mem_addr, mem_cmd},
              {14'd0, b, r, 3'd1});
      end else if (mem_cmd != 3'd0) begin
        seq_bad = 1'b1;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(!seq_bad, "R6 R2 no unexpected command", 32'(seq_bad), 0);
    check(mem_cmd == col_cmd && mem_bank == b && mem_addr == {5'd0, c},
          "R3 R5 column command", {14'd0, mem_bank, mem_addr, mem_cmd},
          {14'd0, b, 5'd0, c, col_cmd});
    if (t_act >= 0) begin
      m_open[b] = 1'b1;
      m_row[b] = r;
      m_act[b] = t_act;
    end
    if (wr) begin
      check(mem_wdata == d, "R9 write data", mem_wdata, d);
      check(mem_wr_en && host_rdy, "R9 write strobes", {30'd0, mem_wr_en, host_rdy}, 3);
      check(req_ready == 1'b1, "R11 ready in write cycle", 32'(req_ready), 1);
    end else begin
      for (int j = 1; j <= 6; j++) begin
        @(negedge clk);
        check(host_rdy == (j >= 3), "R7 read ready timing", 32'(host_rdy), 32'(j >= 3));
        check(mem_cmd == 3'd0, "R10 idle command during burst", 32'(mem_cmd), 0);
        check(req_ready == (j == 6), "R11 ready after last beat", 32'(req_ready),
              32'(j == 6));
        if (j >= 3) begin
          logic [1:0] lo;
          lo = c[1:0] + 2'(j - 3);
          check(host_beat == lo, "R8 beat offset", 32'(host_beat), 32'(lo));
          check(host_rdata == pat(b, r, {c[7:2], lo}), "R7 read data", host_rdata,
                pat(b, r, {c[7:2], lo}));
        end
      end
    end
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd5150);
    // Phase 1: RCD = 2
    do_reset(1'b0);
    run_req(1'b1, 2'd0, 13'd5, 8'h10, 32'hDEAD_0001, 1'b0);   // closed bank
    run_req(1'b0, 2'd0, 13'd5, 8'hFE, 32'h0, 1'b0);           // hit, wrap 2,3,0,1
    run_req(1'b1, 2'd1, 13'd3, 8'h21, 32'hCAFE_0002, 1'b0);   // closed
    run_req(1'b1, 2'd1, 13'd4, 8'h22, 32'hCAFE_0003, 1'b0);   // miss, tRAS floor binds
    run_req(1'b0, 2'd1, 13'd4, 8'h03, 32'h0, 1'b1);           // hit, wrap 3,0,1,2, junk
    run_req(1'b0, 2'd2, 13'h1FFF, 8'hFF, 32'h0, 1'b1);        // closed read, junk
    run_req(1'b0, 2'd2, 13'd0, 8'h01, 32'h0, 1'b0);           // miss right after read
    for (int n = 0; n < 250; n++) begin
      run_req(1'($urandom), 2'($urandom), 13'($urandom % 3), 8'($urandom),
              $urandom, ($urandom % 4) == 0);
    end
    // Phase 2: RCD = 3, reset must forget the open rows
    do_reset(1'b1);
    run_req(1'b0, 2'd1, 13'd4, 8'h02, 32'h0, 1'b0);           // was open before reset
    run_req(1'b1, 2'd1, 13'd7, 8'h40, 32'h1234_5678, 1'b0);   // miss
    run_req(1'b1, 2'd1, 13'd8, 8'h41, 32'h8765_4321, 1'b0);   // miss, tRAS = 5
    for (int n = 0; n < 250; n++) begin
      run_req(1'($urandom), 2'($urandom), 13'($urandom % 3), 8'($urandom),
              $urandom, ($urandom % 4) == 0);
    end
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule